// File: doc/BRIEF.md
# DDR2 Mode Register Command Unit

This block sits on the device side of a DDR2 command bus and handles mode-register programming. Every clock it samples the four active-low command strobes, the two bank-select pins, the thirteen address pins, the clock-enable pin and one idle flag per bank. When all four strobes are low, it treats the cycle as a mode-register command. If the command is legal, it stores the address pins in the register that the bank-select pins name.

For the main mode register, the block decodes the fields on the spot and presents them as ready-to-use outputs: burst length, burst ordering, read latency, write recovery, test mode, power-down exit speed, and a one-cycle DLL reset request. A reserved code in any field is not stored. The field keeps its previous value and a sticky configuration error is raised. The two extended registers are kept as plain 13-bit words.

After each accepted write, the block enforces a programmable lockout window, during which further mode-register commands are refused. A command that arrives while banks are open, while clock enable has not been high for two cycles, or with the reserved selector changes nothing and produces a one-cycle reject pulse.

Top module: `mode_reg_unit`

## Requirements
- R1: A cycle with cs_ni, ras_ni, cas_ni and we_ni all low at a rising edge is a mode-register command. A legal command updates the outputs in the cycle after that edge.
- R2: ba_i selects the target. 2'b00 is the main register, 2'b01 loads emr1_o, and 2'b10 loads emr2_o. 2'b11 is refused: wr_err_o pulses and nothing is stored.
- R3: A command is legal only if every bit of bank_idle_i is 1 and cke_i is high both at that edge and at the edge before. Otherwise wr_err_o is high for one cycle and no output changes.
- R4: mr_valid_o is low after reset. It rises only on the first legal write with ba_i=2'b00 and then stays high.
- R5: addr_i[2:0]=3'b010 gives burst_len_o=4 and 3'b011 gives 8. Every other code is reserved.
- R6: burst_intlv_o takes addr_i[3]: 0 for sequential order, 1 for interleaved order.
- R7: A code c of 3 to 7 on addr_i[6:4] gives cas_lat_o=c. Codes 0 to 2 are reserved.
- R8: A code c of 1 to 7 on addr_i[11:9] gives wr_rec_o=c+1. Code 0 is reserved.
- R9: test_mode_o takes addr_i[7]. pd_slow_o takes addr_i[12]: 0 for fast exit, 1 for slow exit.
- R10: dll_reset_o is high for exactly the one cycle after a legal main-register write with addr_i[8]=1. It is low otherwise.
- R11: A reserved code in the burst length, latency or recovery field sets cfg_err_o, which stays set until reset. That field keeps its previous value while the other fields update.
- R12: After a legal write at edge N with tmrd_i=T, commands at edges N+1 to N+T-1 are refused, and busy_o is high while such an edge remains. A command at edge N+T is accepted. With T of 0 or 1 there is no lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select strobe, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Register selector |
| addr_i | input | 13 | Register payload |
| cke_i | input | 1 | Clock enable |
| bank_idle_i | input | NUM_BANKS | Per-bank precharged flag |
| tmrd_i | input | TMRD_W | Lockout length in cycles |
| mr_valid_o | output | 1 | Main register has been written |
| burst_len_o | output | 4 | Burst length, 4 or 8 |
| burst_intlv_o | output | 1 | Interleaved burst order |
| cas_lat_o | output | 3 | Read latency in cycles |
| test_mode_o | output | 1 | Test mode bit |
| dll_reset_o | output | 1 | One-cycle DLL reset request |
| wr_rec_o | output | 4 | Write recovery in cycles |
| pd_slow_o | output | 1 | Slow power-down exit selected |
| emr1_o | output | 13 | Extended register 1 contents |
| emr2_o | output | 13 | Extended register 2 contents |
| wr_err_o | output | 1 | Command refused, one-cycle pulse |
| cfg_err_o | output | 1 | Sticky reserved-code flag |
| busy_o | output | 1 | Lockout window active |

## Verification
The hardest case to produce is a command that lands exactly on the last locked edge and then exactly on the first free edge. The bench reaches it by issuing commands back to back, one per edge, directly after a write, for each lockout length from 1 to 4. It checks for each attempt whether it was refused and whether the register moved.

The second hard case is clock enable that rises in the command cycle itself. The bench drops cke_i for one cycle and raises it together with the command strobes. The reserved-code handling is covered by sweeping every code of all three coded fields, with the other fields carrying changing legal values, so that partial updates become visible.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int unsigned MR_ADDR_W = 13;

  typedef enum logic [1:0] {
    SEL_MR   = 2'b00,
    SEL_EXT1 = 2'b01,
    SEL_EXT2 = 2'b10,
    SEL_RSVD = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic       bl_ok;
    logic [3:0] bl;
    logic       bt;
    logic       cl_ok;
    logic [2:0] cl;
    logic       tm;
    logic       dll;
    logic       wr_ok;
    logic [3:0] wr;
    logic       pd;
  } mr_fields_t;
endpackage

// File: rtl/mrs_cmd_gate.sv
module mrs_cmd_gate #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned TMRD_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [1:0]           ba_i,
  input  logic                 cke_i,
  input  logic [NUM_BANKS-1:0] bank_idle_i,
  input  logic [TMRD_W-1:0]    tmrd_i,
  output logic                 wr_en_o,
  output logic                 reject_o,
  output logic                 busy_o
);
  import mrs_pkg::*;

  logic              cmd_hit;
  logic              cke_q;
  logic [TMRD_W-1:0] lock_cnt;

  assign cmd_hit  = ~cs_ni & ~ras_ni & ~cas_ni & ~we_ni;
  assign busy_o   = lock_cnt != '0;
  assign wr_en_o  = cmd_hit & cke_q & cke_i & (&bank_idle_i) & ~busy_o
                    & (reg_sel_e'(ba_i) != SEL_RSVD);
  assign reject_o = cmd_hit & ~wr_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  // load T-1 so the T-th edge after a write is free again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lock_cnt <= '0;
    else if (wr_en_o)            lock_cnt <= (tmrd_i == '0) ? '0 : tmrd_i - TMRD_W'(1);
    else if (lock_cnt != '0)     lock_cnt <= lock_cnt - TMRD_W'(1);
  end

  p_cke_prior_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(cke_i));
  p_lock_starts_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && tmrd_i > TMRD_W'(1)) |=> busy_o);
  p_lock_refuses_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_hit) |-> reject_o);
endmodule

// File: rtl/mrs_field_decode.sv
module mrs_field_decode (
  input  logic [12:0]               addr_i,
  output mrs_pkg::mr_fields_t       fields_o
);
  always_comb begin
    fields_o       = '0;
    unique case (addr_i[2:0])
      3'b010:  begin fields_o.bl_ok = 1'b1; fields_o.bl = 4'd4; end
      3'b011:  begin fields_o.bl_ok = 1'b1; fields_o.bl = 4'd8; end
      default: begin fields_o.bl_ok = 1'b0; fields_o.bl = 4'd0; end
    endcase
    fields_o.bt    = addr_i[3];
    fields_o.cl_ok = addr_i[6:4] >= 3'd3;
    fields_o.cl    = addr_i[6:4];
    fields_o.tm    = addr_i[7];
    fields_o.dll   = addr_i[8];
    fields_o.wr_ok = addr_i[11:9] != 3'd0;
    fields_o.wr    = {1'b0, addr_i[11:9]} + 4'd1;
    fields_o.pd    = addr_i[12];
  end
endmodule

// File: rtl/mode_reg_unit.sv
module mode_reg_unit #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned TMRD_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [1:0]           ba_i,
  input  logic [12:0]          addr_i,
  input  logic                 cke_i,
  input  logic [NUM_BANKS-1:0] bank_idle_i,
  input  logic [TMRD_W-1:0]    tmrd_i,
  output logic                 mr_valid_o,
  output logic [3:0]           burst_len_o,
  output logic                 burst_intlv_o,
  output logic [2:0]           cas_lat_o,
  output logic                 test_mode_o,
  output logic                 dll_reset_o,
  output logic [3:0]           wr_rec_o,
  output logic                 pd_slow_o,
  output logic [12:0]          emr1_o,
  output logic [12:0]          emr2_o,
  output logic                 wr_err_o,
  output logic                 cfg_err_o,
  output logic                 busy_o
);
  import mrs_pkg::*;

  localparam int unsigned NUM_EXT = 2;

  logic       wr_en, reject, mr_wr;
  mr_fields_t fld;
  logic [MR_ADDR_W-1:0] ext_q [NUM_EXT];

  mrs_cmd_gate #(.NUM_BANKS(NUM_BANKS), .TMRD_W(TMRD_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .ba_i       (ba_i),
    .cke_i      (cke_i),
    .bank_idle_i(bank_idle_i),
    .tmrd_i     (tmrd_i),
    .wr_en_o    (wr_en),
    .reject_o   (reject),
    .busy_o     (busy_o)
  );

  mrs_field_decode u_dec (
    .addr_i  (addr_i),
    .fields_o(fld)
  );

  assign mr_wr = wr_en & (reg_sel_e'(ba_i) == SEL_MR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mr_valid_o    <= 1'b0;
      burst_len_o   <= '0;
      burst_intlv_o <= 1'b0;
      cas_lat_o     <= '0;
      test_mode_o   <= 1'b0;
      wr_rec_o      <= '0;
      pd_slow_o     <= 1'b0;
      cfg_err_o     <= 1'b0;
    end else if (mr_wr) begin
      mr_valid_o    <= 1'b1;
      burst_intlv_o <= fld.bt;
      test_mode_o   <= fld.tm;
      pd_slow_o     <= fld.pd;
      if (fld.bl_ok) burst_len_o <= fld.bl;
      if (fld.cl_ok) cas_lat_o   <= fld.cl;
      if (fld.wr_ok) wr_rec_o    <= fld.wr;
      if (!(fld.bl_ok && fld.cl_ok && fld.wr_ok)) cfg_err_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_reset_o <= 1'b0;
      wr_err_o    <= 1'b0;
    end else begin
      dll_reset_o <= mr_wr & fld.dll;
      wr_err_o    <= reject;
    end
  end

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ext_q[g] <= '0;
      else if (wr_en && ba_i == 2'(g + 1))           ext_q[g] <= addr_i;
    end
  end

  assign emr1_o = ext_q[0];
  assign emr2_o = ext_q[1];

  p_valid_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mr_valid_o) |-> mr_valid_o);
  p_cfg_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_err_o) |-> cfg_err_o);
  p_refused_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> ($stable(burst_len_o) && $stable(cas_lat_o) && $stable(wr_rec_o)
                  && $stable(mr_valid_o) && $stable(emr1_o) && $stable(emr2_o)));
  p_bl_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_len_o == 4'd0 || burst_len_o == 4'd4 || burst_len_o == 4'd8);
  p_cl_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_lat_o == 3'd0 || cas_lat_o >= 3'd3);
  p_wr_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rec_o != 4'd1 && wr_rec_o <= 4'd8);
  p_dll_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_reset_o |-> mr_valid_o);
endmodule

// File: tb/mode_reg_unit_test.sv
module mode_reg_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        cke = 1'b0;
  logic [7:0]  idle = 8'hFF;
  logic [3:0]  tmrd = 4'd2;
  logic        valid, bt, tm, dll, pd, wr_err, cfg_err, busy;
  logic [3:0]  bl, wr;
  logic [2:0]  cl;
  logic [12:0] emr1, emr2;

  int tests = 0, fails = 0;
  int e_bl = 0, e_cl = 0, e_wr = 0;
  bit e_bt = 0, e_tm = 0, e_pd = 0, e_valid = 0, e_cfg = 0;
  logic [12:0] e_emr1 = '0, e_emr2 = '0;

  always #2 clk = ~clk;

  mode_reg_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .ba_i(ba), .addr_i(addr), .cke_i(cke), .bank_idle_i(idle),
    .tmrd_i(tmrd), .mr_valid_o(valid), .burst_len_o(bl), .burst_intlv_o(bt),
    .cas_lat_o(cl), .test_mode_o(tm), .dll_reset_o(dll), .wr_rec_o(wr),
    .pd_slow_o(pd), .emr1_o(emr1), .emr2_o(emr2), .wr_err_o(wr_err),
    .cfg_err_o(cfg_err), .busy_o(busy)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the result visible
  task automatic cmd(logic [1:0] b, logic [12:0] a, bit ke = 1'b1);
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; ba = b; addr = a; cke = ke;
    @(negedge clk);
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
  endtask

  task automatic model_write(logic [1:0] b, logic [12:0] a);
    if (b == 2'd1) e_emr1 = a;
    else if (b == 2'd2) e_emr2 = a;
    else if (b == 2'd0) begin
      e_valid = 1;
      if (a[2:0] == 3'd2) e_bl = 4; else if (a[2:0] == 3'd3) e_bl = 8; else e_cfg = 1;
      if (a[6:4] >= 3) e_cl = int'(a[6:4]); else e_cfg = 1;
      if (a[11:9] != 0) e_wr = int'(a[11:9]) + 1; else e_cfg = 1;
      e_bt = a[3]; e_tm = a[7]; e_pd = a[12];
    end
  endtask

  task automatic check_all();
    chk("R4 valid", int'(valid), int'(e_valid));
    chk("R5 burst length", int'(bl), e_bl);
    chk("R6 burst type", int'(bt), int'(e_bt));
    chk("R7 cas latency", int'(cl), e_cl);
    chk("R8 write recovery", int'(wr), e_wr);
    chk("R9 test mode", int'(tm), int'(e_tm));
    chk("R9 pd exit", int'(pd), int'(e_pd));
    chk("R11 cfg error", int'(cfg_err), int'(e_cfg));
    chk("R2 emr1", int'(emr1), int'(e_emr1));
    chk("R2 emr2", int'(emr2), int'(e_emr2));
  endtask

  function automatic logic [12:0] mk(int bl_c, int bt_c, int cl_c, int tm_c,
                                     int dll_c, int wr_c, int pd_c);
    return 13'((pd_c << 12) | (wr_c << 9) | (dll_c << 8) | (tm_c << 7)
               | (cl_c << 4) | (bt_c << 3) | bl_c);
  endfunction

  // legal write with full checking and the one-cycle lockout spacing for tmrd=2
  task automatic good_write(logic [1:0] b, logic [12:0] a);
    cmd(b, a);
    model_write(b, a);
    chk("R1 no reject", int'(wr_err), 0);
    check_all();
    chk("R10 dll pulse", int'(dll), int'(b == 2'd0 && a[8]));
    @(negedge clk);
    chk("R10 dll one cycle", int'(dll), 0);
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset valid", int'(valid), 0);
    chk("R11 reset cfg", int'(cfg_err), 0);
    chk("R10 reset dll", int'(dll), 0);
    chk("R3 reset err", int'(wr_err), 0);
    chk("R12 reset busy", int'(busy), 0);
    rst_ni = 1; cke = 1;
    repeat (2) @(negedge clk);

    // R2/R4: extended writes do not validate the main register
    good_write(2'd1, 13'h1A5);
    good_write(2'd2, 13'h0F3);
    chk("R4 still invalid", int'(valid), 0);

    // R1: clean first write, no config error
    good_write(2'd0, mk(3, 0, 5, 0, 1, 3, 0));
    chk("R11 clean write", int'(cfg_err), 0);

    // R3: one bank open
    idle = 8'hEF;
    cmd(2'd0, mk(2, 1, 3, 0, 1, 1, 1));
    chk("R3 bank busy reject", int'(wr_err), 1);
    check_all();
    chk("R10 no dll on reject", int'(dll), 0);
    idle = 8'hFF;
    @(negedge clk);
    chk("R3 err one cycle", int'(wr_err), 0);

    // R3: cke rises with the command
    cke = 0;
    @(negedge clk);
    cmd(2'd1, 13'h0777, 1'b1);
    chk("R3 cke late reject", int'(wr_err), 1);
    check_all();
    @(negedge clk);

    // R2: reserved selector
    cmd(2'd3, 13'h1FFF);
    chk("R2 reserved sel reject", int'(wr_err), 1);
    check_all();
    chk("R12 no lock after reject", int'(busy), 0);
    @(negedge clk);

    // R5-R11 sweep every field code
    for (int i = 0; i < 64; i++) begin
      good_write(2'd0, mk(i % 8, (i >> 1) & 1, (i >> 3) % 8, (i >> 4) & 1,
                          (i >> 2) & 1, (i * 3) % 8, (i >> 5) & 1));
    end
    good_write(2'd1, 13'h0ABC);

    // R12: lockout length sweep
    for (int t = 1; t <= 4; t++) begin
      logic [12:0] a0 = 13'(100 + t);
      logic [12:0] a1 = 13'(200 + t);
      tmrd = 4'(t);
      cmd(2'd1, a0);
      e_emr1 = a0;
      chk("R12 first accepted", int'(wr_err), 0);
      chk("R12 busy after write", int'(busy), int'(t > 1));
      for (int k = 1; k <= t; k++) begin
        cmd(2'd1, a1);
        chk("R12 refuse window", int'(wr_err), int'(k < t));
        chk("R12 register", int'(emr1), int'((k >= t) ? a1 : a0));
        if (k < t) chk("R12 busy count", int'(busy), int'(k < t - 1));
      end
      e_emr1 = a1;
      repeat (5) @(negedge clk);
    end
    tmrd = 4'd0;
    cmd(2'd2, 13'h0123);
    cmd(2'd2, 13'h0456);
    chk("R12 zero lockout", int'(wr_err), 0);
    chk("R12 zero lockout data", int'(emr2), 'h456);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule